// File: doc/BRIEF.md
# Dual-Modulus Swallow Counter Divider

This block is the feedback divider of an integer-N synthesizer loop. A fast input clock drives a divide-by-10/11 prescaler. The prescaler's output advances a main counter, and a swallow counter decides which prescaler cycles stretch to eleven input clocks. One output period therefore covers 10×(M+1)+A input clocks. When bypass is set, every input clock advances the main counter directly and the period is M+1 input clocks.

The output `div_out` is a one-clock pulse that marks the end of each complete divide period. `mod_sel` shows which modulus the prescaler is using. The divide settings are plain control pins and are not a data stream, so there is no valid/ready handshake. The block takes in the settings only at a period boundary, so software may change them at any time without cutting a period short. A direct-pin mode keeps only the low seven bits of M. The prescaler is modelled as synchronous logic clocked by the input clock.

Top module: `dmd_divider`

## Requirements
- R1: With bypass low, consecutive `div_out` pulses are exactly 10×(Me+1)+Ae input clocks apart, where Me and Ae are the effective M and A of R5–R7.
- R2: With bypass low, `mod_sel` is high for exactly 11×Ae input clocks at the start of each period and low for the rest of that period. These are the first Ae prescaler cycles, each of which divides by 11.
- R3: With bypass high, consecutive pulses are Me+1 input clocks apart and `mod_sel` stays low.
- R4: `div_out` is high for exactly one input clock in each period.
- R5: An M value of 0 after masking is treated as 1, so the smallest ratio is 2 in bypass and 20+Ae with the prescaler.
- R6: An A value greater than Me+1 is clamped to Me+1.
- R7: With `direct_mode` high, M bits 8 and 7 are forced to zero, so Me uses only `m_val[6:0]`.
- R8: `m_val`, `a_val`, `bypass` and `direct_mode` are sampled only on the clock edge on which `div_out` rises. That edge starts the next period with the sampled values. A change made at any other time leaves the current period unchanged.
- R9: A synchronous `rst` clears all counters and holds `div_out` low. During reset the settings are captured from the inputs, and `mod_sel` is high during reset if and only if Ae>0 and bypass is low. The first period after release counts from the first clock edge with `rst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| m_val | input | 9 | Main counter setting M |
| a_val | input | 4 | Swallow count A |
| bypass | input | 1 | High: skip the prescaler; divide by M+1 |
| direct_mode | input | 1 | High: force M bits 8 and 7 to zero |
| div_out | output | 1 | One-clock pulse at the end of each period |
| mod_sel | output | 1 | High while the prescaler divides by 11 |

## Verification
Two events can fall on the same clock edge: the main counter's terminal count, which ends the period, and the sampling of new settings. The bench changes the settings on the last half-cycle before an expected pulse. It then checks that the period containing the change keeps its old length and that the very next period already has the new length. It also makes a change on the half-cycle just after a pulse and in mid-period, and expects the old length to hold until the following boundary.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
  localparam int DEF_M_W      = 9;   // main counter setting width
  localparam int DEF_A_W      = 4;   // swallow count width
  localparam int DEF_DIV_LO   = 10;  // low modulus; high modulus is DIV_LO+1
  localparam int DEF_DIRECT_W = 7;   // M bits kept in direct-pin mode

  typedef enum logic {MOD_LO = 1'b0, MOD_HI = 1'b1} modulus_e;
endpackage

// File: rtl/dmd_cfg.sv
module dmd_cfg #(
  parameter int M_W      = dmd_pkg::DEF_M_W,
  parameter int A_W      = dmd_pkg::DEF_A_W,
  parameter int DIRECT_W = dmd_pkg::DEF_DIRECT_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [M_W-1:0] m_in,
  input  logic [A_W-1:0] a_in,
  input  logic           byp_in,
  input  logic           direct_in,
  output logic [A_W-1:0] a_next,
  output logic [M_W-1:0] m_q,
  output logic [A_W-1:0] a_q,
  output logic           byp_q
);
  localparam logic [M_W-1:0] KEEP_MASK = M_W'((1 << DIRECT_W) - 1);
  localparam int             EXT_W     = M_W + 1;

  logic [M_W-1:0] m_masked;
  logic [M_W-1:0] m_fix;
  logic [EXT_W-1:0] m_plus;
  logic [EXT_W-1:0] a_ext;

  // R7 mask, R5 zero fix, R6 clamp
  always_comb begin
    m_masked = direct_in ? (m_in & KEEP_MASK) : m_in;
    m_fix    = (m_masked == '0) ? M_W'(1) : m_masked;
    m_plus   = {1'b0, m_fix} + EXT_W'(1);
    a_ext    = EXT_W'(a_in);
    a_next   = (a_ext > m_plus) ? m_plus[A_W-1:0] : a_in;
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      m_q   <= m_fix;
      a_q   <= a_next;
      byp_q <= byp_in;
    end
  end
endmodule

// File: rtl/dmd_prescaler.sv
module dmd_prescaler #(
  parameter int DIV_LO = dmd_pkg::DEF_DIV_LO
) (
  input  logic clk,
  input  logic rst,
  input  logic byp,
  input  dmd_pkg::modulus_e modulus,
  output logic tick
);
  localparam int PW = $clog2(DIV_LO + 1);

  logic [PW-1:0] pc;
  logic [PW-1:0] last;

  always_comb begin
    last = (modulus == dmd_pkg::MOD_HI) ? PW'(DIV_LO) : PW'(DIV_LO - 1);
    tick = byp || (pc == last);
  end

  always_ff @(posedge clk) begin
    if (rst || tick) pc <= '0;
    else             pc <= pc + PW'(1);
  end
endmodule

// File: rtl/dmd_swallow.sv
module dmd_swallow #(
  parameter int A_W = dmd_pkg::DEF_A_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           tick,
  input  logic [A_W-1:0] a_next,
  output dmd_pkg::modulus_e modulus,
  output logic [A_W-1:0] a_rem
);
  always_ff @(posedge clk) begin
    if (rst || load)             a_rem <= a_next;
    else if (tick && a_rem != '0) a_rem <= a_rem - A_W'(1);
  end

  assign modulus = (a_rem != '0) ? dmd_pkg::MOD_HI : dmd_pkg::MOD_LO;
endmodule

// File: rtl/dmd_main_cnt.sv
module dmd_main_cnt #(
  parameter int M_W = dmd_pkg::DEF_M_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [M_W-1:0] m_q,
  output logic [M_W-1:0] mc,
  output logic           boundary
);
  assign boundary = tick && (mc == m_q);

  always_ff @(posedge clk) begin
    if (rst || boundary) mc <= '0;
    else if (tick)       mc <= mc + M_W'(1);
  end
endmodule

// File: rtl/dmd_divider.sv
module dmd_divider #(
  parameter int M_W      = dmd_pkg::DEF_M_W,
  parameter int A_W      = dmd_pkg::DEF_A_W,
  parameter int DIV_LO   = dmd_pkg::DEF_DIV_LO,
  parameter int DIRECT_W = dmd_pkg::DEF_DIRECT_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [M_W-1:0] m_val,
  input  logic [A_W-1:0] a_val,
  input  logic           bypass,
  input  logic           direct_mode,
  output logic           div_out,
  output logic           mod_sel
);
  logic [A_W-1:0] a_next;
  logic [M_W-1:0] m_q;
  logic [A_W-1:0] a_q;
  logic           byp_q;
  logic [A_W-1:0] a_rem;
  logic [M_W-1:0] mc;
  logic           tick;
  logic           boundary;
  dmd_pkg::modulus_e modulus;

  dmd_cfg #(.M_W(M_W), .A_W(A_W), .DIRECT_W(DIRECT_W)) u_cfg (
    .clk(clk), .rst(rst), .load(boundary),
    .m_in(m_val), .a_in(a_val), .byp_in(bypass), .direct_in(direct_mode),
    .a_next(a_next), .m_q(m_q), .a_q(a_q), .byp_q(byp_q)
  );

  dmd_prescaler #(.DIV_LO(DIV_LO)) u_pre (
    .clk(clk), .rst(rst), .byp(byp_q), .modulus(modulus), .tick(tick)
  );

  dmd_swallow #(.A_W(A_W)) u_swl (
    .clk(clk), .rst(rst), .load(boundary), .tick(tick),
    .a_next(a_next), .modulus(modulus), .a_rem(a_rem)
  );

  dmd_main_cnt #(.M_W(M_W)) u_main (
    .clk(clk), .rst(rst), .tick(tick), .m_q(m_q),
    .mc(mc), .boundary(boundary)
  );

  always_ff @(posedge clk) begin
    if (rst) div_out <= 1'b0;
    else     div_out <= boundary;
  end

  assign mod_sel = (modulus == dmd_pkg::MOD_HI) && !byp_q;
endmodule

// File: rtl/dmd_divider_chk.sv
module dmd_divider_chk #(
  parameter int M_W = dmd_pkg::DEF_M_W,
  parameter int A_W = dmd_pkg::DEF_A_W
) (
  input logic           clk,
  input logic           rst,
  input logic           div_out,
  input logic           mod_sel,
  input logic           boundary,
  input logic           byp_q,
  input logic [M_W-1:0] m_q,
  input logic [A_W-1:0] a_q,
  input logic [M_W-1:0] mc
);
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out);

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> ($stable(m_q) && $stable(a_q) && $stable(byp_q)));

  p_bypass_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    byp_q |-> !mod_sel);

  p_count_range_r1: assert property (@(posedge clk) disable iff (rst)
    mc <= m_q);

  p_m_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    m_q != '0);

  p_swallow_clamp_r6: assert property (@(posedge clk) disable iff (rst)
    (M_W + 1)'(a_q) <= ({1'b0, m_q} + (M_W + 1)'(1)));

  p_modsel_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_sel) |-> $past(boundary));
endmodule

bind dmd_divider dmd_divider_chk #(.M_W(M_W), .A_W(A_W)) u_chk (
  .clk(clk), .rst(rst), .div_out(div_out), .mod_sel(mod_sel),
  .boundary(boundary), .byp_q(byp_q), .m_q(m_q), .a_q(a_q), .mc(mc)
);

// File: tb/tb_dmd_divider.sv
`timescale 1ns/1ps
module tb_dmd_divider;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] m_val = 9'd3;
  logic [3:0] a_val = 4'd2;
  logic       bypass = 1'b0;
  logic       direct_mode = 1'b0;
  logic       div_out, mod_sel;

  int tests = 0, fails = 0;
  int chg_at = -1;
  logic [8:0] chg_m; logic [3:0] chg_a; logic chg_b, chg_d;

  always #2.5 clk = ~clk;

  dmd_divider dut (.clk(clk), .rst(rst), .m_val(m_val), .a_val(a_val),
    .bypass(bypass), .direct_mode(direct_mode), .div_out(div_out), .mod_sel(mod_sel));

  function automatic int eff_m(int m, bit d);
    int v = d ? (m & 127) : m;
    return (v == 0) ? 1 : v;
  endfunction
  function automatic int eff_a(int m, int a, bit d);
    int me = eff_m(m, d);
    return (a > me + 1) ? me + 1 : a;
  endfunction
  function automatic int exp_per(int m, int a, bit b, bit d);
    int me = eff_m(m, d);
    return b ? me + 1 : 10 * (me + 1) + eff_a(m, a, d);
  endfunction
  function automatic int exp_ms(int m, int a, bit b, bit d);
    return b ? 0 : 11 * eff_a(m, a, d);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(int m, int a, bit b, bit d);
    m_val = 9'(m); a_val = 4'(a); bypass = b; direct_mode = d;
  endtask

  // Call at a negedge where a period starts; returns clocks to the next pulse
  task automatic wait_pulse(output int per, output int ms);
    per = 0; ms = 0;
    do begin
      ms += int'(mod_sel);
      @(negedge clk);
      per++;
      if (per == chg_at) begin
        set_cfg(chg_m, chg_a, chg_b, chg_d);
        chg_at = -1;
      end
      if (per > 6000) begin
        check(0, "R1", "pulse timeout", per, 0);
        break;
      end
    end while (!div_out);
  endtask

  task automatic measure(int m, int a, bit b, bit d, string req);
    int per, ms;
    set_cfg(m, a, b, d);
    wait_pulse(per, ms);                  // old setting still running (R8)
    wait_pulse(per, ms);
    check(per == exp_per(m, a, b, d), req, "period", per, exp_per(m, a, b, d));
    check(ms == exp_ms(m, a, b, d), b ? "R3" : "R2", "mod_sel clocks", ms, exp_ms(m, a, b, d));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "R1", "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int per, ms, pold, pnew;
    void'($urandom(32'd4242));
    // R9 reset state
    set_cfg(3, 2, 0, 0);
    repeat (3) @(negedge clk);
    check(div_out == 1'b0, "R9", "div_out in reset", int'(div_out), 0);
    check(mod_sel == 1'b1, "R9", "mod_sel in reset", int'(mod_sel), 1);
    rst = 1'b0;
    wait_pulse(per, ms);
    check(per == 42, "R9", "first period after release", per, 42);
    check(ms == 22, "R2", "first mod_sel clocks", ms, 22);
    // R4 pulse width
    @(negedge clk);
    check(div_out == 1'b0, "R4", "pulse width", int'(div_out), 0);
    wait_pulse(per, ms);
    check(per == 41, "R4", "period after width probe", per, 41);

    measure(20, 0, 0, 0, "R1");
    measure(511, 15, 0, 0, "R1");
    measure(1, 2, 0, 0, "R1");
    measure(9, 7, 1, 0, "R3");
    measure(511, 3, 1, 0, "R3");
    measure(1, 0, 1, 0, "R5");
    measure(0, 0, 1, 0, "R5");
    measure(0, 5, 0, 0, "R5");
    measure(1, 15, 0, 0, "R6");
    measure(4, 9, 0, 0, "R6");
    measure(9'h1FF, 4, 0, 1, "R7");
    measure(9'h185, 1, 0, 1, "R7");
    measure(9'h180, 0, 1, 1, "R7");

    // R8: change on the last half-cycle before the pulse edge
    pold = exp_per(9'h180, 0, 1, 1);
    chg_m = 9'd6; chg_a = 4'd3; chg_b = 0; chg_d = 0; chg_at = pold - 1;
    wait_pulse(per, ms);
    check(per == pold, "R8", "late change keeps period", per, pold);
    pnew = exp_per(6, 3, 0, 0);
    wait_pulse(per, ms);
    check(per == pnew, "R8", "late change next period", per, pnew);
    // R8: change in mid-period
    chg_m = 9'd12; chg_a = 4'd1; chg_b = 0; chg_d = 0; chg_at = pnew / 2;
    wait_pulse(per, ms);
    check(per == pnew, "R8", "mid change keeps period", per, pnew);
    wait_pulse(per, ms);
    check(per == exp_per(12, 1, 0, 0), "R8", "mid change next period", per, exp_per(12, 1, 0, 0));

    // R9 reset in mid-period
    repeat (17) @(negedge clk);
    rst = 1'b1; set_cfg(2, 1, 0, 0);
    repeat (2) @(negedge clk);
    check(div_out == 1'b0, "R9", "div_out during mid reset", int'(div_out), 0);
    rst = 1'b0;
    wait_pulse(per, ms);
    check(per == 31, "R9", "period after mid reset", per, 31);

    for (int i = 0; i < 25; i++) begin
      int m = int'($urandom_range(0, 45));
      int a = int'($urandom_range(0, 15));
      bit b = ($urandom_range(0, 3) == 0);
      bit d = ($urandom_range(0, 3) == 0);
      if (d) m += 128 * int'($urandom_range(0, 3));
      measure(m, a, b, d, b ? "R3" : "R1");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule